// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Tail-Chaining

This block sits beside a simple processor model and decides which interrupt handler runs and when. Each of its request lines has an enable bit, a pending bit and a two-bit urgency level. An arbiter picks the best request that is both pending and enabled. A sequencing state machine then models what the processor does around a handler. It saves context when it leaves thread mode, runs the handler body, restores context on the way out, and takes the short tail-chain path when another handler can follow without restoring context first.

Saving and restoring context are modelled as fixed cycle counts. The handler body lasts for the number of cycles presented on `hdl_cycles_i` when the body starts. A handler that has been preempted keeps its remaining cycle count on a small internal stack of frames and resumes from that count. Configuration goes through a one-cycle write strobe with a selector, a source index and a data word. There is no streaming data path, so no port carries valid/ready handshakes and no port can apply back-pressure. A write is always accepted in the cycle its strobe is high.

Top module: `irq_tailchain_ctrl`

## Requirements
- R1: Among sources that are both pending and enabled, the one with the numerically lowest level wins; among equal levels the lowest source index wins. `pend_vec_o` shows the winner as index+1, or 0 when there is none, in the same cycle as the pending and enable state it reflects.
- R2: A running handler is preempted only by a candidate whose level is strictly lower than its own. A candidate at the same level or a higher level waits.
- R3: All enables are clear after reset. A write with `cfg_sel`=0 sets every enable bit whose `cfg_wdata` bit is 1, and leaves bits written with 0 unchanged.
- R4: A write with `cfg_sel`=1 clears every pending bit whose `cfg_wdata` bit is 1 and leaves bits written with 0 untouched. A request that arrives in the same cycle as the clear leaves its pending bit set.
- R5: Leaving thread mode costs STACK_CYC cycles (12) in phase 1. The body then lasts `hdl_cycles_i` cycles (minimum 1) in phase 2. A return to thread or to a preempted handler costs STACK_CYC cycles in phase 4.
- R6: When a body ends and the best candidate has strictly higher urgency than the context being returned to, the controller spends CHAIN_CYC cycles (6) in phase 3 and enters that handler with no phase 4. Thread mode ranks below every level.
- R7: Otherwise the controller restores context. If it was returning to a preempted handler, that handler resumes with the body cycles it had left.
- R8: A request for a source whose handler is already running sets its pending bit again, and that source is serviced again after the handler exits.
- R9: A source's pending bit clears when entry to its handler begins. A disabled source stays pending and is never selected.
- R10: `phase_o` encodes 0 thread, 1 entry stacking, 2 handler body, 3 tail-chain, 4 exit unstacking. `active_vec_o` shows index+1 of the handler being sequenced, and is 0 in thread mode.
- R11: A write with `cfg_sel`=2 sets the level of source `cfg_idx` to `cfg_wdata[1:0]`. All levels are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_SRC | Request lines; a high sample sets the pending bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 set-enable, 1 clear-pending, 2 level, 3 no effect |
| cfg_idx | input | IDX_W | Source index for level writes |
| cfg_wdata | input | N_SRC | Write data (bit mask, or level in bits 1:0) |
| hdl_cycles_i | input | CNT_W | Handler body length, sampled when a body starts |
| phase_o | output | 3 | Sequencer phase |
| active_vec_o | output | VEC_W | Active handler as index+1, 0 in thread mode |
| pend_vec_o | output | VEC_W | Best pending enabled source as index+1, 0 if none |
| enable_o | output | N_SRC | Enable bits |
| pending_o | output | N_SRC | Pending bits |

## Verification
The bench builds the controller with four sources and keeps the default 12-cycle stacking and 6-cycle chaining costs. With four sources, every unordered pair of sources under all sixteen level combinations can be raised together, and every ordered pair can be raised with the second arriving one cycle into the first handler's body. Between them these sweeps cover tie-breaks, strict preemption and same-level waiting exhaustively. Three-deep nesting with a late third request at every level shows chaining into a preempted handler and falling back to a restore. The bench derives the handler length from the active vector, so each handler's body has a distinct length that can be predicted.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    PH_THREAD  = 3'd0,
    PH_STACK   = 3'd1,
    PH_RUN     = 3'd2,
    PH_CHAIN   = 3'd3,
    PH_UNSTACK = 3'd4
  } phase_e;

  localparam logic [1:0] CFG_SETEN   = 2'd0;
  localparam logic [1:0] CFG_CLRPEND = 2'd1;
  localparam logic [1:0] CFG_PRIO    = 2'd2;

  localparam int PRIO_W = 2;
  localparam int LEVELS = 4;
endpackage

// File: rtl/intc_srcregs.sv
module intc_srcregs
  import intc_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_SRC-1:0]              irq_i,
  input  logic                          cfg_we,
  input  logic [1:0]                    cfg_sel,
  input  logic [IDX_W-1:0]              cfg_idx,
  input  logic [N_SRC-1:0]              cfg_wdata,
  input  logic                          take_i,
  input  logic [IDX_W-1:0]              take_idx_i,
  output logic [N_SRC-1:0]              enable_o,
  output logic [N_SRC-1:0]              pending_o,
  output logic [N_SRC-1:0][PRIO_W-1:0]  prio_o
);
  logic [N_SRC-1:0] clr_mask, take_mask, pend_n;

  always_comb begin
    clr_mask  = (cfg_we && cfg_sel == CFG_CLRPEND) ? cfg_wdata : '0;
    take_mask = take_i ? (N_SRC'(1) << take_idx_i) : '0;
    // new requests win over any clear in the same cycle
    pend_n    = (pending_o & ~clr_mask & ~take_mask) | irq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_o  <= '0;
      pending_o <= '0;
    end else begin
      pending_o <= pend_n;
      if (cfg_we && cfg_sel == CFG_SETEN)
        enable_o <= enable_o | cfg_wdata;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_level
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prio_o[g] <= '0;
      else if (cfg_we && cfg_sel == CFG_PRIO && cfg_idx == IDX_W'(g))
        prio_o[g] <= cfg_wdata[PRIO_W-1:0];
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic [N_SRC-1:0]              req_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0]  prio_i,
  output logic                          vld_o,
  output logic [IDX_W-1:0]              idx_o,
  output logic [PRIO_W-1:0]             prio_o
);
  // scan from the top index down; "<=" lets lower indices win ties
  always_comb begin
    vld_o  = 1'b0;
    idx_o  = '0;
    prio_o = '1;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (req_i[k] && (!vld_o || prio_i[k] <= prio_o)) begin
        vld_o  = 1'b1;
        idx_o  = IDX_W'(k);
        prio_o = prio_i[k];
      end
    end
  end
endmodule

// File: rtl/intc_ctxstack.sv
module intc_ctxstack #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic [W-1:0]                 data_i,
  output logic [W-1:0]                 top_o,
  output logic [$clog2(DEPTH+1)-1:0]   depth_o
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];

  assign top_o = (depth_o == '0) ? '0 : mem[IW'(depth_o - PW'(1))];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_o <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (push_i && depth_o != PW'(DEPTH)) begin
      mem[IW'(depth_o)] <= data_i;
      depth_o           <= depth_o + PW'(1);
    end else if (pop_i && depth_o != '0) begin
      depth_o <= depth_o - PW'(1);
    end
  end
endmodule

// File: rtl/irq_tailchain_ctrl.sv
module irq_tailchain_ctrl
  import intc_pkg::*;
#(
  parameter int N_SRC     = 8,
  parameter int CNT_W     = 8,
  parameter int STACK_CYC = 12,
  parameter int CHAIN_CYC = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [N_SRC-1:0]                   irq_i,
  input  logic                               cfg_we,
  input  logic [1:0]                         cfg_sel,
  input  logic [(N_SRC>1?$clog2(N_SRC):1)-1:0] cfg_idx,
  input  logic [N_SRC-1:0]                   cfg_wdata,
  input  logic [CNT_W-1:0]                   hdl_cycles_i,
  output logic [2:0]                         phase_o,
  output logic [$clog2(N_SRC+1)-1:0]         active_vec_o,
  output logic [$clog2(N_SRC+1)-1:0]         pend_vec_o,
  output logic [N_SRC-1:0]                   enable_o,
  output logic [N_SRC-1:0]                   pending_o
);
  localparam int IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int VEC_W   = $clog2(N_SRC + 1);
  localparam int CTX_W   = PRIO_W + 1;
  localparam int FRAME_W = VEC_W + CTX_W + CNT_W;
  localparam int DEP_W   = $clog2(LEVELS + 1);
  localparam logic [CTX_W-1:0] THREAD_LVL = CTX_W'(LEVELS);

  phase_e             phase_q, phase_n;
  logic [VEC_W-1:0]   vec_q, vec_n;
  logic [CTX_W-1:0]   ctxp_q, ctxp_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;

  logic [N_SRC-1:0][PRIO_W-1:0] prio;
  logic               best_vld;
  logic [IDX_W-1:0]   best_idx;
  logic [PRIO_W-1:0]  best_prio;
  logic [CTX_W-1:0]   best_lvl, ret_lvl;
  logic [VEC_W-1:0]   best_vec;
  logic               take, push, pop;
  logic [FRAME_W-1:0] top_frame;
  logic [DEP_W-1:0]   depth;
  logic [CNT_W-1:0]   body_len;

  intc_srcregs #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .take_i(take), .take_idx_i(best_idx),
    .enable_o(enable_o), .pending_o(pending_o), .prio_o(prio)
  );

  intc_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .req_i(pending_o & enable_o), .prio_i(prio),
    .vld_o(best_vld), .idx_o(best_idx), .prio_o(best_prio)
  );

  intc_ctxstack #(.DEPTH(LEVELS), .W(FRAME_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
    .data_i({vec_q, ctxp_q, cnt_q}), .top_o(top_frame), .depth_o(depth)
  );

  assign best_lvl = {1'b0, best_prio};
  assign best_vec = VEC_W'(best_idx) + VEC_W'(1);
  assign ret_lvl  = (depth != '0) ? top_frame[CNT_W +: CTX_W] : THREAD_LVL;
  assign body_len = (hdl_cycles_i == '0) ? CNT_W'(1) : hdl_cycles_i;

  always_comb begin
    phase_n = phase_q;
    vec_n   = vec_q;
    ctxp_n  = ctxp_q;
    cnt_n   = cnt_q - CNT_W'(1);
    take    = 1'b0;
    push    = 1'b0;
    pop     = 1'b0;
    unique case (phase_q)
      PH_THREAD: begin
        cnt_n = cnt_q;
        if (best_vld) begin
          take = 1'b1; phase_n = PH_STACK;
          vec_n = best_vec; ctxp_n = best_lvl; cnt_n = CNT_W'(STACK_CYC);
        end
      end
      PH_STACK, PH_CHAIN: begin
        if (cnt_q == CNT_W'(1)) begin
          phase_n = PH_RUN; cnt_n = body_len;
        end
      end
      PH_RUN: begin
        if (best_vld && best_lvl < ctxp_q) begin
          push = 1'b1; take = 1'b1; phase_n = PH_STACK;
          vec_n = best_vec; ctxp_n = best_lvl; cnt_n = CNT_W'(STACK_CYC);
        end else if (cnt_q == CNT_W'(1)) begin
          if (best_vld && best_lvl < ret_lvl) begin
            take = 1'b1; phase_n = PH_CHAIN;
            vec_n = best_vec; ctxp_n = best_lvl; cnt_n = CNT_W'(CHAIN_CYC);
          end else begin
            phase_n = PH_UNSTACK; cnt_n = CNT_W'(STACK_CYC);
          end
        end
      end
      PH_UNSTACK: begin
        if (cnt_q == CNT_W'(1)) begin
          if (depth != '0) begin
            pop = 1'b1; phase_n = PH_RUN;
            vec_n  = top_frame[FRAME_W-1 -: VEC_W];
            ctxp_n = top_frame[CNT_W +: CTX_W];
            cnt_n  = top_frame[CNT_W-1:0];
          end else begin
            phase_n = PH_THREAD; vec_n = '0; ctxp_n = THREAD_LVL; cnt_n = '0;
          end
        end
      end
      default: begin
        phase_n = PH_THREAD; vec_n = '0; ctxp_n = THREAD_LVL; cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_THREAD;
      vec_q   <= '0;
      ctxp_q  <= THREAD_LVL;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_n;
      vec_q   <= vec_n;
      ctxp_q  <= ctxp_n;
      cnt_q   <= cnt_n;
    end
  end

  assign phase_o      = phase_q;
  assign active_vec_o = vec_q;
  assign pend_vec_o   = best_vld ? best_vec : '0;
endmodule

// File: rtl/irq_tailchain_chk.sv
module irq_tailchain_chk
  import intc_pkg::*;
#(
  parameter int N_SRC     = 8,
  parameter int VEC_W     = 4,
  parameter int CTX_W     = 3,
  parameter int STACK_CYC = 12,
  parameter int CHAIN_CYC = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       phase,
  input logic [VEC_W-1:0] active_vec,
  input logic [VEC_W-1:0] pend_vec,
  input logic [N_SRC-1:0] enable,
  input logic [CTX_W-1:0] act_lvl
);
  logic [2:0]       prev_ph;
  logic [VEC_W-1:0] prev_vec;
  logic [CTX_W-1:0] prev_lvl;
  logic [N_SRC-1:0] prev_en;
  logic [15:0]      seg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ph  <= 3'd0;
      prev_vec <= '0;
      prev_lvl <= '0;
      prev_en  <= '0;
      seg      <= '0;
    end else begin
      prev_ph  <= phase;
      prev_vec <= active_vec;
      prev_lvl <= act_lvl;
      prev_en  <= enable;
      seg      <= (phase == prev_ph && active_vec == prev_vec) ? seg + 16'd1 : 16'd1;
    end
  end

  a_r5_stack_len: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != prev_ph && prev_ph == PH_STACK) |-> seg == 16'(STACK_CYC));
  a_r5_unstack_len: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != prev_ph && prev_ph == PH_UNSTACK) |-> seg == 16'(STACK_CYC));
  a_r6_chain_len: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != prev_ph && prev_ph == PH_CHAIN) |-> seg == 16'(CHAIN_CYC));
  a_r2_preempt_strict: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STACK && prev_ph == PH_RUN) |-> act_lvl < prev_lvl);
  a_r9_thread_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_THREAD && pend_vec != '0) |=>
      (phase == PH_STACK && active_vec == $past(pend_vec)));
  a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_en & ~enable) == '0);
  a_r10_thread_vec: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_THREAD |-> active_vec == '0);
  a_r10_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 3'd4);
endmodule

bind irq_tailchain_ctrl irq_tailchain_chk #(
  .N_SRC(N_SRC), .VEC_W(VEC_W), .CTX_W(CTX_W),
  .STACK_CYC(STACK_CYC), .CHAIN_CYC(CHAIN_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase_o), .active_vec(active_vec_o),
  .pend_vec(pend_vec_o), .enable(enable_o), .act_lvl(ctxp_q)
);

// File: tb/tb_irq_tailchain_ctrl.sv
module tb_irq_tailchain_ctrl;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [1:0] cfg_idx = '0;
  logic [N-1:0] cfg_wdata = '0;
  logic [7:0] hdl;
  logic [2:0] phase;
  logic [2:0] active_vec, pend_vec;
  logic [N-1:0] enable, pending;

  always #10 clk = ~clk;

  assign hdl = 8'(4 + 2 * int'(active_vec));

  irq_tailchain_ctrl #(.N_SRC(N)) dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .hdl_cycles_i(hdl), .phase_o(phase), .active_vec_o(active_vec),
    .pend_vec_o(pend_vec), .enable_o(enable), .pending_o(pending)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  // segment recorder: (phase, vector, length) runs outside thread mode
  bit rec_on = 1'b0;
  int seg_ph[64], seg_vec[64], seg_len[64];
  int nseg = 0;
  int cur_ph = 0, cur_vec = 0, cur_len = 0;
  int exp_ph[64], exp_vec[64], exp_len[64];
  int nexp = 0;

  always @(negedge clk) begin
    cycles++;
    if (!rec_on) begin
      nseg = 0; cur_ph = 0; cur_vec = 0; cur_len = 0;
    end else if (int'(phase) == cur_ph && int'(active_vec) == cur_vec) begin
      cur_len++;
    end else begin
      if (cur_ph != 0 && nseg < 64) begin
        seg_ph[nseg] = cur_ph; seg_vec[nseg] = cur_vec; seg_len[nseg] = cur_len;
        nseg++;
      end
      cur_ph = int'(phase); cur_vec = int'(active_vec); cur_len = 1;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int hlen(int v);
    return 4 + 2 * v;
  endfunction

  task automatic add_exp(int ph, int v, int len);
    exp_ph[nexp] = ph; exp_vec[nexp] = v; exp_len[nexp] = len;
    nexp++;
  endtask

  task automatic cfg_write(int sel, int idx, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_idx = 2'(idx); cfg_wdata = N'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq = '0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic setup(int p0, int p1, int p2, int p3);
    do_reset();
    cfg_write(2, 0, p0);
    cfg_write(2, 1, p1);
    cfg_write(2, 2, p2);
    cfg_write(2, 3, p3);
    cfg_write(0, 0, 4'hF);
    nexp = 0;
    rec_on = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_now(int mask);
    irq = N'(mask);
    @(negedge clk);
    irq = '0;
  endtask

  task automatic wait_run(int v, string tag);
    for (int t = 0; t < 2000; t++) begin
      if (phase == 3'd2 && int'(active_vec) == v) return;
      @(negedge clk);
    end
    check({tag, " timeout waiting for body"}, 0, 1);
  endtask

  task automatic wait_done(string tag);
    int t;
    for (t = 0; t < 3000 && phase == 3'd0; t++) @(negedge clk);
    for (t = 0; t < 3000 && phase != 3'd0; t++) @(negedge clk);
    if (t >= 3000) check({tag, " timeout waiting for thread"}, 0, 1);
    @(negedge clk);
  endtask

  task automatic compare(string tag);
    check({tag, " segment count"}, nseg, nexp);
    for (int k = 0; k < nexp && k < nseg; k++)
      check({tag, " segment ph*10000+vec*1000+len"},
            seg_ph[k] * 10000 + seg_vec[k] * 1000 + seg_len[k],
            exp_ph[k] * 10000 + exp_vec[k] * 1000 + exp_len[k]);
    rec_on = 1'b0;
  endtask

  function automatic int lvl_of(int s, int p0, int p1, int p2, int p3);
    case (s)
      0: return p0;
      1: return p1;
      2: return p2;
      default: return p3;
    endcase
  endfunction

  initial begin : watchdog
    wait (cycles > 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual %0d expected below 190000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    // ---- reset state and configuration registers ----
    do_reset();
    check("R10 reset phase", int'(phase), 0);
    check("R10 reset active vector", int'(active_vec), 0);
    check("R3 reset enables", int'(enable), 0);
    check("R4 reset pending", int'(pending), 0);
    check("R1 reset best vector", int'(pend_vec), 0);

    pulse_now(4'b0110);
    check("R9 disabled requests latch", int'(pending), 4'b0110);
    check("R9 disabled not selected", int'(pend_vec), 0);
    repeat (3) @(negedge clk);
    check("R9 disabled no entry", int'(phase), 0);

    cfg_write(1, 0, 4'b0100);
    check("R4 w1c clears only ones", int'(pending), 4'b0010);

    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 4'b0110; irq = 4'b0100;
    @(negedge clk);
    cfg_we = 1'b0; irq = '0;
    check("R4 request beats same-cycle clear", int'(pending), 4'b0100);

    cfg_write(0, 0, 4'b0001);
    check("R3 set-enable", int'(enable), 4'b0001);
    cfg_write(0, 0, 4'b0000);
    check("R3 zero write keeps enables", int'(enable), 4'b0001);
    cfg_write(3, 0, 4'b1111);
    check("R3 unused selector no effect", int'(enable), 4'b0001);

    cfg_write(2, 1, 2);
    cfg_write(2, 3, 1);
    pulse_now(4'b1010);
    check("R1 nothing enabled and pending", int'(pend_vec), 0);
    cfg_write(0, 0, 4'b1010);
    check("R11 R1 lower level wins", int'(pend_vec), 4);
    check("R1 no entry yet", int'(phase), 0);
    @(negedge clk);
    check("R9 entry begins", int'(phase), 1);
    check("R9 entry vector", int'(active_vec), 4);
    check("R9 pending cleared on entry", int'(pending), 4'b0110);
    check("R1 next best", int'(pend_vec), 2);
    wait_done("R9");
    check("R9 disabled stays pending", int'(pending), 4'b0100);
    check("R9 idle best vector", int'(pend_vec), 0);

    // ---- simultaneous pairs, all level combinations ----
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        for (int pc = 0; pc < 16; pc++) begin
          int pi, pj, f, s;
          pi = pc % 4; pj = pc / 4;
          setup(i == 0 ? pi : (j == 0 ? pj : 3), i == 1 ? pi : (j == 1 ? pj : 3),
                i == 2 ? pi : (j == 2 ? pj : 3), i == 3 ? pi : (j == 3 ? pj : 3));
          f = (pi <= pj) ? i : j;
          s = (f == i) ? j : i;
          add_exp(1, f + 1, 12);
          add_exp(2, f + 1, hlen(f + 1));
          add_exp(3, s + 1, 6);
          add_exp(2, s + 1, hlen(s + 1));
          add_exp(4, s + 1, 12);
          pulse_now((1 << i) | (1 << j));
          wait_done("R1 R5 R6 pair");
          compare("R1 R5 R6 pair");
        end

    // ---- second request one cycle into the first body ----
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (i != j)
          for (int pc = 0; pc < 16; pc++) begin
            int pi, pj, vi, vj;
            pi = pc % 4; pj = pc / 4; vi = i + 1; vj = j + 1;
            setup(i == 0 ? pi : (j == 0 ? pj : 3), i == 1 ? pi : (j == 1 ? pj : 3),
                  i == 2 ? pi : (j == 2 ? pj : 3), i == 3 ? pi : (j == 3 ? pj : 3));
            add_exp(1, vi, 12);
            if (pj < pi) begin
              add_exp(2, vi, 2);
              add_exp(1, vj, 12);
              add_exp(2, vj, hlen(vj));
              add_exp(4, vj, 12);
              add_exp(2, vi, hlen(vi) - 1);
              add_exp(4, vi, 12);
            end else begin
              add_exp(2, vi, hlen(vi));
              add_exp(3, vj, 6);
              add_exp(2, vj, hlen(vj));
              add_exp(4, vj, 12);
            end
            pulse_now(1 << i);
            wait_run(vi, "R2");
            pulse_now(1 << j);
            wait_done("R2 R7 preempt");
            compare("R2 R7 preempt");
          end

    // ---- three deep: chain into a preempted handler only if more urgent ----
    for (int kidx = 0; kidx < 2; kidx++)
      for (int p = 0; p < 4; p++) begin
        int vk;
        vk = kidx + 1;
        setup(kidx == 0 ? p : 3, kidx == 1 ? p : 3, 0, 1);
        add_exp(1, 4, 12);
        add_exp(2, 4, 2);
        add_exp(1, 3, 12);
        add_exp(2, 3, hlen(3));
        if (p == 0) begin
          add_exp(3, vk, 6);
          add_exp(2, vk, hlen(vk));
          add_exp(4, vk, 12);
          add_exp(2, 4, hlen(4) - 1);
          add_exp(4, 4, 12);
        end else begin
          add_exp(4, 3, 12);
          add_exp(2, 4, hlen(4) - 1);
          add_exp(3, vk, 6);
          add_exp(2, vk, hlen(vk));
          add_exp(4, vk, 12);
        end
        pulse_now(1 << 3);
        wait_run(4, "R6");
        pulse_now(1 << 2);
        wait_run(3, "R6");
        pulse_now(1 << kidx);
        wait_done("R6 R7 nested");
        compare("R6 R7 nested");
      end

    // ---- same source requested again while its handler runs ----
    for (int s = 0; s < N; s++) begin
      setup(s, 3 - s, 2, 1);
      add_exp(1, s + 1, 12);
      add_exp(2, s + 1, hlen(s + 1));
      add_exp(3, s + 1, 6);
      add_exp(2, s + 1, hlen(s + 1));
      add_exp(4, s + 1, 12);
      pulse_now(1 << s);
      wait_run(s + 1, "R8");
      pulse_now(1 << s);
      wait_done("R8 re-request");
      compare("R8 re-request");
      check("R8 nothing left pending", int'(pending), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule